// File: doc/BRIEF.md
# Push-Button Debouncer with Press Pulse

This block turns the bouncing level of a mechanical push-button into a clean level and a single-cycle press event. The raw key passes through a synchronizer on the system clock. A counter derived from the clock frequency and a sample period produces a slow enable strobe, typically every 8 ms. On each strobe the synchronized key is shifted into a short chain of sample flops.

A set/reset holding register watches that chain. When every sample is high it is set. When every sample is low it is cleared. When the samples disagree it keeps its value. A bounce or noise spike shorter than one sample period can reach at most one sample, so it can never make the chain unanimous.

A one-stage differentiator after the holding register emits a pulse one clock wide for each confirmed press. A counter downstream therefore counts a long press once. The strobe period must be at least four times shorter than the period of any scan or display logic that consumes the result.

Top module: `btn_filter`

## Requirements
- R1: While `rst_i` is high at a clock edge, `key_level_o` and `press_pulse_o` become 0 and every sample is cleared to 0, whatever `key_raw_i` does.
- R2: A sample strobe is high for one clock in every TICK_CYCLES = (CLK_HZ / 1000000) * SAMPLE_US clocks. It is first high in the TICK_CYCLES-th cycle after reset is released. The sample chain shifts only on strobe cycles.
- R3: When all AGREE_N samples in the chain are 1, `key_level_o` is 1 from the clock after the strobe that completed the agreement.
- R4: When all AGREE_N samples in the chain are 0, `key_level_o` is 0 from the clock after the strobe that completed the agreement.
- R5: While the samples in the chain disagree, `key_level_o` keeps its previous value. A key toggling once per sample period never changes the level.
- R6: A pulse on `key_raw_i` shorter than one sample period cannot change `key_level_o`. This requires AGREE_N of at least 2.
- R7: `press_pulse_o` is 1 for exactly one clock, in the clock cycle that follows the cycle in which `key_level_o` went from 0 to 1.
- R8: `press_pulse_o` stays 0 while the key is held and when it is released. Each confirmed press gives exactly one pulse.
- R9: `key_raw_i` passes through SYNC_STAGES flops on the system clock before it is sampled. Elaboration rejects AGREE_N < 2, SYNC_STAGES < 2, SAMPLE_US < 1 or CLK_HZ < 1000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| key_raw_i | input | 1 | Raw, asynchronous push-button level, 1 = pressed |
| key_level_o | output | 1 | Debounced key level |
| press_pulse_o | output | 1 | One-clock pulse per confirmed press |

## Verification
The assertions take for granted that reset is held for at least one clock before the first check. They also assume that the strobe counter and the bound checker's gap counter start together from that reset. The raw key is assumed to change only between clock edges, so the synchronizer sees no metastable value. The stimulus keeps to these assumptions by driving the key and reset only on the falling clock edge. It drives the key in random level runs from one clock to several sample periods, which produces both disagreeing and unanimous sample chains. Directed runs add short glitches and a toggle at exactly the sample rate.

// File: rtl/btn_filter_pkg.sv
package btn_filter_pkg;

   // Command to the holding register derived from the sample chain
   typedef struct packed {
      logic set;
      logic clr;
   } hold_cmd_t;

   typedef enum logic [1:0] {
      HOLD_KEEP = 2'b00,
      HOLD_CLR  = 2'b01,
      HOLD_SET  = 2'b10
   } hold_op_e;

   function automatic hold_op_e hold_decode(input hold_cmd_t cmd);
      if (cmd.set && !cmd.clr)      return HOLD_SET;
      else if (cmd.clr && !cmd.set) return HOLD_CLR;
      else                          return HOLD_KEEP;
   endfunction

endpackage

// File: rtl/btn_filter_tick.sv
module btn_filter_tick #(
   parameter int unsigned TICK = 8
) (
   input  logic clk_i,
   input  logic rst_i,
   output logic strobe_o
);
   localparam int unsigned CW = (TICK > 1) ? $clog2(TICK) : 1;

   generate
      if (TICK < 1) begin : g_bad
         $error("btn_filter_tick: TICK must be at least 1");
      end
      if (TICK == 1) begin : g_every
         assign strobe_o = 1'b1;
      end else begin : g_count
         logic [CW-1:0] cnt_q;
         logic          wrap;

         assign wrap = (cnt_q == CW'(TICK - 1));

         always_ff @(posedge clk_i) begin
            if (rst_i)      cnt_q <= '0;
            else if (wrap)  cnt_q <= '0;
            else            cnt_q <= cnt_q + 1'b1;
         end

         assign strobe_o = wrap;
      end
   endgenerate

endmodule

// File: rtl/btn_filter_sync.sv
module btn_filter_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] stg_q;

   generate
      if (STAGES < 2) begin : g_bad
         $error("btn_filter_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk_i) begin
               if (rst_i) stg_q[0] <= 1'b0;
               else       stg_q[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk_i) begin
               if (rst_i) stg_q[i] <= 1'b0;
               else       stg_q[i] <= stg_q[i-1];
            end
         end
      end
   endgenerate

   assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/btn_filter_vote.sv
module btn_filter_vote
   import btn_filter_pkg::*;
#(
   parameter int unsigned AGREE_N = 2
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic               strobe_i,
   input  logic               sample_i,
   output logic [AGREE_N-1:0] chain_o,
   output logic               level_o
);
   logic [AGREE_N-1:0] chain_q;
   hold_cmd_t          cmd;
   logic               level_q;

   generate
      if (AGREE_N < 2) begin : g_bad
         $error("btn_filter_vote: AGREE_N must be at least 2");
      end
   endgenerate

   // Shift chain advances only on strobe cycles
   always_ff @(posedge clk_i) begin
      if (rst_i)         chain_q <= '0;
      else if (strobe_i) chain_q <= {chain_q[AGREE_N-2:0], sample_i};
   end

   // Unanimous-vote set/reset command
   always_comb begin
      cmd.set = &chain_q;
      cmd.clr = ~|chain_q;
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         level_q <= 1'b0;
      end else begin
         unique case (hold_decode(cmd))
            HOLD_SET: level_q <= 1'b1;
            HOLD_CLR: level_q <= 1'b0;
            default:  level_q <= level_q;
         endcase
      end
   end

   assign chain_o = chain_q;
   assign level_o = level_q;

endmodule

// File: rtl/btn_filter_edge.sv
module btn_filter_edge (
   input  logic clk_i,
   input  logic rst_i,
   input  logic level_i,
   output logic pulse_o
);
   logic prev_q;
   logic pulse_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         prev_q  <= 1'b0;
         pulse_q <= 1'b0;
      end else begin
         prev_q  <= level_i;
         pulse_q <= level_i & ~prev_q;
      end
   end

   assign pulse_o = pulse_q;

endmodule

// File: rtl/btn_filter.sv
module btn_filter #(
   parameter int unsigned CLK_HZ      = 50_000_000,
   parameter int unsigned SAMPLE_US   = 8000,
   parameter int unsigned AGREE_N     = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic key_raw_i,
   output logic key_level_o,
   output logic press_pulse_o
);
   localparam int unsigned CYC_PER_US  = CLK_HZ / 1_000_000;
   localparam int unsigned TICK_CYCLES = CYC_PER_US * SAMPLE_US;

   generate
      if (CLK_HZ < 1_000_000) begin : g_bad_clk
         $error("btn_filter: CLK_HZ must be at least 1 MHz");
      end
      if (SAMPLE_US < 1) begin : g_bad_period
         $error("btn_filter: SAMPLE_US must be at least 1");
      end
   endgenerate

   logic               strobe;
   logic               key_sync;
   logic [AGREE_N-1:0] chain;
   logic               level;

   btn_filter_tick #(.TICK(TICK_CYCLES)) tick_i (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .strobe_o (strobe)
   );

   btn_filter_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .d_i   (key_raw_i),
      .q_o   (key_sync)
   );

   btn_filter_vote #(.AGREE_N(AGREE_N)) vote_i (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .strobe_i (strobe),
      .sample_i (key_sync),
      .chain_o  (chain),
      .level_o  (level)
   );

   btn_filter_edge edge_i (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .level_i (level),
      .pulse_o (press_pulse_o)
   );

   assign key_level_o = level;

endmodule

// File: rtl/btn_filter_chk.sv
module btn_filter_chk #(
   parameter int unsigned AGREE_N = 2,
   parameter int unsigned TICK    = 8
) (
   input logic               clk_i,
   input logic               rst_i,
   input logic               strobe,
   input logic [AGREE_N-1:0] chain,
   input logic               level,
   input logic               pulse
);
   localparam int unsigned GW = $clog2(TICK + 1) + 1;

   logic [GW-1:0] gap_q;

   always_ff @(posedge clk_i) begin
      if (rst_i)       gap_q <= '0;
      else if (strobe) gap_q <= '0;
      else             gap_q <= gap_q + 1'b1;
   end

   // R2: strobe spacing equals the derived tick count
   assert_tick_spacing_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      strobe |-> (gap_q == GW'(TICK - 1)));

   // R2: samples held between strobes
   assert_chain_stable_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      !strobe |=> $stable(chain));

   // R3: level rises only after a unanimous high chain
   assert_rise_agree_R3: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(level) |-> $past(&chain));

   // R4: level falls only after a unanimous low chain
   assert_fall_agree_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      $fell(level) |-> $past(~|chain));

   // R5: disagreeing samples keep the level
   assert_hold_mixed_R5: assert property (@(posedge clk_i) disable iff (rst_i)
      (|chain && !(&chain)) |=> $stable(level));

   // R7: a rise is followed by a pulse
   assert_pulse_follows_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(level) |=> pulse);

   // R7: the pulse is one clock wide
   assert_pulse_single_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      pulse |=> !pulse);

   // R8: a pulse only ever comes from a fresh rise
   assert_pulse_source_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      pulse |-> ($past(level) && !$past(level, 2)));

endmodule

bind btn_filter btn_filter_chk #(
   .AGREE_N (AGREE_N),
   .TICK    (TICK_CYCLES)
) chk_i (
   .clk_i  (clk_i),
   .rst_i  (rst_i),
   .strobe (strobe),
   .chain  (chain),
   .level  (level),
   .pulse  (press_pulse_o)
);

// File: tb/btn_filter_tb_top.sv
module btn_filter_tb_top;
   localparam int unsigned CLK_HZ = 1_000_000;
   localparam int unsigned SAMP   = 8;
   localparam int unsigned AGREE  = 3;
   localparam int unsigned SYNC   = 2;
   localparam int unsigned T      = (CLK_HZ / 1_000_000) * SAMP;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic key = 1'b0;
   logic lvl;
   logic pls;

   int n_tests = 0;
   int n_fail  = 0;
   bit live    = 1'b0;
   bit done    = 1'b0;

   int dut_pulses = 0;
   int ref_rises  = 0;

   always #2.5 clk = ~clk;

   btn_filter #(
      .CLK_HZ(CLK_HZ), .SAMPLE_US(SAMP), .AGREE_N(AGREE), .SYNC_STAGES(SYNC)
   ) dut_i (
      .clk_i(clk), .rst_i(rst), .key_raw_i(key),
      .key_level_o(lvl), .press_pulse_o(pls)
   );

   // Reference model built from the requirements
   int unsigned      m_cnt   = 0;
   logic [SYNC-1:0]  m_sync  = '0;
   logic [AGREE-1:0] m_chain = '0;
   logic             m_lvl   = 1'b0;
   logic             m_prev  = 1'b0;
   logic             m_pls   = 1'b0;

   always @(posedge clk) begin
      logic             stb;
      logic [AGREE-1:0] n_chain;
      logic             n_lvl;
      logic             n_pls;
      if (rst) begin
         m_cnt = 0; m_sync = '0; m_chain = '0;
         m_lvl = 1'b0; m_prev = 1'b0; m_pls = 1'b0;
      end else begin
         stb     = (m_cnt == T - 1);
         n_chain = stb ? {m_chain[AGREE-2:0], m_sync[SYNC-1]} : m_chain;
         if (&m_chain)       n_lvl = 1'b1;
         else if (~|m_chain) n_lvl = 1'b0;
         else                n_lvl = m_lvl;
         n_pls   = m_lvl & ~m_prev;
         m_cnt   = stb ? 0 : m_cnt + 1;
         m_sync  = {m_sync[SYNC-2:0], key};
         m_chain = n_chain;
         m_prev  = m_lvl;
         m_lvl   = n_lvl;
         m_pls   = n_pls;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // Cycle-by-cycle comparison on the falling edge
   always @(negedge clk) begin
      if (live && !rst) begin
         check(lvl == m_lvl, "R3 R4 R9 level", lvl, m_lvl);
         check(pls == m_pls, "R7 pulse", pls, m_pls);
         if (pls) dut_pulses++;
         if (m_pls) ref_rises++;
      end
   end

   task automatic hold(input logic v, input int n);
      key = v;
      repeat (n) @(negedge clk);
   endtask

   task automatic summary;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   initial begin
      repeat (150_000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         summary();
         $finish;
      end
   end

   initial begin
      int p0;
      int l0;
      void'($urandom(32'h0BAD_5EED));
      @(negedge clk);
      key = 1'b1;
      repeat (6) @(negedge clk);
      // R1: outputs cleared during reset even with key pressed
      check(lvl == 1'b0, "R1 level in reset", lvl, 0);
      check(pls == 1'b0, "R1 pulse in reset", pls, 0);
      key = 1'b0;
      @(negedge clk);
      rst  = 1'b0;
      live = 1'b1;
      hold(1'b0, 4 * T);
      check(lvl == 1'b0, "R1 level after reset", lvl, 0);

      // R3 R8: long press gives level 1 and a single pulse
      p0 = dut_pulses;
      hold(1'b1, 30 * T);
      check(lvl == 1'b1, "R3 long press level", lvl, 1);
      check(dut_pulses - p0 == 1, "R8 one pulse per press", dut_pulses - p0, 1);

      // R6: short glitch low while held
      hold(1'b0, T - 3);
      hold(1'b1, 6 * T);
      check(lvl == 1'b1, "R6 glitch while held", lvl, 1);

      // R5: toggle at the sample rate keeps the level
      for (int i = 0; i < 12; i++) hold(i[0], T);
      check(lvl == 1'b1, "R5 toggle keeps high", lvl, 1);

      // R4 R8: release clears level with no pulse
      p0 = dut_pulses;
      hold(1'b0, 8 * T);
      check(lvl == 1'b0, "R4 release level", lvl, 0);
      check(dut_pulses == p0, "R8 no pulse on release", dut_pulses - p0, 0);

      // R6: short glitch high while released
      hold(1'b1, T - 2);
      hold(1'b0, 6 * T);
      check(lvl == 1'b0, "R6 glitch while released", lvl, 0);

      // Random runs of levels
      for (int i = 0; i < 400; i++) begin
         int len;
         if ($urandom_range(3) == 0) len = $urandom_range(1, T - 1);
         else                       len = $urandom_range(1, 6 * T);
         hold(1'(($urandom_range(1))), len);
      end
      hold(1'b0, 8 * T);
      check(dut_pulses == ref_rises, "R8 pulse count random", dut_pulses, ref_rises);

      // R1: reset mid-operation while pressed
      hold(1'b1, 10 * T);
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check(lvl == 1'b0 && pls == 1'b0, "R1 mid-run reset", lvl, 0);
      rst = 1'b0;
      l0 = 0;
      for (int i = 0; i < (AGREE - 1) * T; i++) begin
         @(negedge clk);
         if (lvl) l0 = 1;
      end
      check(l0 == 0, "R1 samples cleared by reset", l0, 0);
      hold(1'b1, 6 * T);
      check(lvl == 1'b1, "R3 press after reset", lvl, 1);

      done = 1'b1;
      live = 1'b0;
      summary();
      $finish;
   end

endmodule